// File: doc/BRIEF.md
# LZ77 Encoder Inverse-Comparison Checker

This block sits at the output of an LZ77 encoder and checks it while it runs, without a second copy of the encoder. Every codeword the encoder produces (a back distance, a copy length and a literal) is expanded back into symbols. The copy symbols are read from a private history memory that holds the symbols rebuilt so far, and the literal comes last. Each rebuilt symbol is compared with the original source symbol. The source symbols wait in a small delay FIFO until the matching rebuilt symbol is ready.

A codeword leaves the block only after all of its symbols have compared equal. A codeword that fails any comparison is withheld. In its place the block gives a one-cycle error pulse, together with the stream index of the first symbol that disagreed. A sticky flag records that an error has happened and stays set until software clears it. If the source FIFO is pushed while it is full, the symbol is dropped, an error pulse is raised and the index of the dropped symbol is reported.

Top module: `lzinv_checker`

## Requirements
- R1: After reset, `out_valid`, `err_pulse` and `err_sticky` are 0 and `cw_ready` is 1.
- R2: A codeword with distance field k and length field L expands to L copy symbols followed by the literal `cw_lit`. Copy symbol j is the rebuilt symbol k+1 positions before it in the stream, so a copy may overlap symbols of the same codeword. The released `out_dist`, `out_len` and `out_lit` equal the accepted fields.
- R3: Rebuilt symbols are compared in stream order against the oldest waiting source symbol, one per cycle. Expansion stalls while no source symbol waits, and nothing is released before the last source symbol of the codeword has arrived.
- R4: A codeword whose symbols all compare equal is released with `out_valid` high for exactly one cycle, and `err_pulse` stays low.
- R5: A codeword with any mismatch is not released. Instead `err_pulse` is high for one cycle, and `err_index` gives the 0-based index, counted over all symbols compared since reset, of its first mismatching symbol.
- R6: `cw_ready` is high only while no codeword is being expanded. When source symbols are already waiting, the result of a codeword of length L appears L+1 cycles after the cycle in which it is accepted.
- R7: The source FIFO holds 2^ceil(log2(MAX_LEN+1)) symbols. A push into a full FIFO with no pop in the same cycle drops the symbol and raises `err_pulse` in the next cycle. `err_index` then gives the 0-based index of the dropped symbol among all source symbols offered since reset.
- R8: `err_sticky` becomes 1 with any error pulse and stays 1 until `err_clear` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source symbol present this cycle |
| src_sym | input | SYM_W | Source symbol |
| cw_valid | input | 1 | Codeword offered |
| cw_dist | input | DICT_AW | Distance field; k means k+1 symbols back |
| cw_len | input | LEN_W | Copy length |
| cw_lit | input | SYM_W | Literal that follows the copy |
| cw_ready | output | 1 | Codeword accepted when high together with cw_valid |
| out_valid | output | 1 | Checked codeword released (one cycle) |
| out_dist | output | DICT_AW | Released distance field |
| out_len | output | LEN_W | Released length field |
| out_lit | output | SYM_W | Released literal |
| err_pulse | output | 1 | One-cycle error indication |
| err_index | output | IDX_W | Index of the failing or dropped symbol |
| err_sticky | output | 1 | Error seen since the last clear |
| err_clear | input | 1 | Clears err_sticky |

## Verification
The bench sweeps every copy length from 0 to 7 against every distance from 1 to 8 with a correct encoder. This covers overlapping copies, where a copy reads symbols rebuilt earlier in the same codeword, and non-overlapping ones. It also checks that each codeword is released after exactly L+1 cycles. A literal corrupted in the codeword and a wrong distance separate the mismatch paths from the release path and fix the reported index. Codewords offered before their source symbols, with gaps between the pushes, exercise the stall. A burst of nine pushes into an eight-entry FIFO exercises the drop path, and the sticky flag is checked before and after it is cleared.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  typedef enum logic [0:0] {
    EXP_IDLE = 1'b0,
    EXP_RUN  = 1'b1
  } exp_state_t;
endpackage

// File: rtl/lzc_src_fifo.sv
module lzc_src_fifo #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  // R3
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/lzc_history.sv
module lzc_history #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lzc_expander.sv
module lzc_expander
  import lzc_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int DICT_AW = 8,
  parameter int LEN_W   = 4,
  parameter int IDX_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cw_valid,
  input  logic [DICT_AW-1:0] cw_dist,
  input  logic [LEN_W-1:0]   cw_len,
  input  logic [SYM_W-1:0]   cw_lit,
  output logic               cw_ready,
  input  logic               src_empty,
  input  logic [SYM_W-1:0]   src_sym,
  output logic               src_pop,
  output logic [DICT_AW-1:0] hist_raddr,
  input  logic [SYM_W-1:0]   hist_rdata,
  output logic               hist_we,
  output logic [DICT_AW-1:0] hist_waddr,
  output logic [SYM_W-1:0]   hist_wdata,
  output logic [DICT_AW-1:0] held_dist,
  output logic [LEN_W-1:0]   held_len,
  output logic [SYM_W-1:0]   held_lit,
  output logic               fin_ok,
  output logic               fin_bad,
  output logic [IDX_W-1:0]   bad_idx
);
  exp_state_t         state_q;
  logic [DICT_AW-1:0] dist_q, wptr_q;
  logic [LEN_W-1:0]   len_q, cnt_q;
  logic [SYM_W-1:0]   lit_q;
  logic               bad_q;
  logic [IDX_W-1:0]   bad_idx_q, sym_idx_q;

  logic             step, is_lit, mism, fin;
  logic [SYM_W-1:0] rec;

  assign cw_ready   = (state_q == EXP_IDLE);
  assign step       = (state_q == EXP_RUN) && !src_empty;
  assign is_lit     = (cnt_q == len_q);
  assign hist_raddr = wptr_q - dist_q - DICT_AW'(1);
  assign rec        = is_lit ? lit_q : hist_rdata;
  assign mism       = step && (rec != src_sym);
  assign fin        = step && is_lit;

  assign src_pop    = step;
  assign hist_we    = step;
  assign hist_waddr = wptr_q;
  assign hist_wdata = rec;

  assign fin_ok  = fin && !bad_q && !mism;
  assign fin_bad = fin && (bad_q || mism);
  assign bad_idx = bad_q ? bad_idx_q : sym_idx_q;

  assign held_dist = dist_q;
  assign held_len  = len_q;
  assign held_lit  = lit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= EXP_IDLE;
      dist_q    <= '0;
      len_q     <= '0;
      lit_q     <= '0;
      cnt_q     <= '0;
      bad_q     <= 1'b0;
      bad_idx_q <= '0;
      sym_idx_q <= '0;
      wptr_q    <= '0;
    end else begin
      case (state_q)
        EXP_IDLE: begin
          if (cw_valid) begin
            dist_q  <= cw_dist;
            len_q   <= cw_len;
            lit_q   <= cw_lit;
            cnt_q   <= '0;
            bad_q   <= 1'b0;
            state_q <= EXP_RUN;
          end
        end
        default: begin
          if (step) begin
            wptr_q    <= wptr_q + DICT_AW'(1);
            sym_idx_q <= sym_idx_q + IDX_W'(1);
            cnt_q     <= cnt_q + LEN_W'(1);
            if (mism && !bad_q) begin
              bad_q     <= 1'b1;
              bad_idx_q <= sym_idx_q;
            end
            if (is_lit) state_q <= EXP_IDLE;
          end
        end
      endcase
    end
  end

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cw_valid && cw_ready) |=> !cw_ready);
  // R6
  busy_until_fin_chk: assert property (@(posedge clk) disable iff (rst)
    (!cw_ready && !fin) |=> !cw_ready);
endmodule

// File: rtl/lzinv_checker.sv
module lzinv_checker #(
  parameter int SYM_W   = 8,
  parameter int DICT_AW = 8,
  parameter int MAX_LEN = 15,
  parameter int IDX_W   = 16,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_valid,
  input  logic [SYM_W-1:0]   src_sym,
  input  logic               cw_valid,
  input  logic [DICT_AW-1:0] cw_dist,
  input  logic [LEN_W-1:0]   cw_len,
  input  logic [SYM_W-1:0]   cw_lit,
  output logic               cw_ready,
  output logic               out_valid,
  output logic [DICT_AW-1:0] out_dist,
  output logic [LEN_W-1:0]   out_len,
  output logic [SYM_W-1:0]   out_lit,
  output logic               err_pulse,
  output logic [IDX_W-1:0]   err_index,
  output logic               err_sticky,
  input  logic               err_clear
);
  localparam int FIFO_AW = LEN_W;

  logic               f_push, f_pop, f_empty, f_full, ovf;
  logic [SYM_W-1:0]   f_dout;
  logic [DICT_AW-1:0] h_raddr, h_waddr;
  logic [SYM_W-1:0]   h_rdata, h_wdata;
  logic               h_we;
  logic [DICT_AW-1:0] held_dist;
  logic [LEN_W-1:0]   held_len;
  logic [SYM_W-1:0]   held_lit;
  logic               fin_ok, fin_bad;
  logic [IDX_W-1:0]   bad_idx, src_idx_q;

  assign f_push = src_valid && (!f_full || f_pop);
  assign ovf    = src_valid && f_full && !f_pop;

  lzc_src_fifo #(.W(SYM_W), .AW(FIFO_AW)) u_fifo (
    .clk(clk), .rst(rst), .push(f_push), .din(src_sym), .pop(f_pop),
    .dout(f_dout), .empty(f_empty), .full(f_full)
  );

  lzc_history #(.W(SYM_W), .AW(DICT_AW)) u_hist (
    .clk(clk), .we(h_we), .waddr(h_waddr), .wdata(h_wdata),
    .raddr(h_raddr), .rdata(h_rdata)
  );

  lzc_expander #(.SYM_W(SYM_W), .DICT_AW(DICT_AW), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_exp (
    .clk(clk), .rst(rst),
    .cw_valid(cw_valid), .cw_dist(cw_dist), .cw_len(cw_len), .cw_lit(cw_lit),
    .cw_ready(cw_ready),
    .src_empty(f_empty), .src_sym(f_dout), .src_pop(f_pop),
    .hist_raddr(h_raddr), .hist_rdata(h_rdata),
    .hist_we(h_we), .hist_waddr(h_waddr), .hist_wdata(h_wdata),
    .held_dist(held_dist), .held_len(held_len), .held_lit(held_lit),
    .fin_ok(fin_ok), .fin_bad(fin_bad), .bad_idx(bad_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_dist   <= '0;
      out_len    <= '0;
      out_lit    <= '0;
      err_pulse  <= 1'b0;
      err_index  <= '0;
      err_sticky <= 1'b0;
      src_idx_q  <= '0;
    end else begin
      out_valid <= fin_ok;
      if (fin_ok) begin
        out_dist <= held_dist;
        out_len  <= held_len;
        out_lit  <= held_lit;
      end
      err_pulse <= fin_bad || ovf;
      if (fin_bad)  err_index <= bad_idx;
      else if (ovf) err_index <= src_idx_q;
      if (fin_bad || ovf) err_sticky <= 1'b1;
      else if (err_clear) err_sticky <= 1'b0;
      if (src_valid) src_idx_q <= src_idx_q + IDX_W'(1);
    end
  end

  // R4
  release_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R5
  release_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && err_pulse));
  // R8
  sticky_follows_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_sticky);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && !err_clear) |=> err_sticky);
endmodule

// File: tb/lzinv_checker_test.sv
`timescale 1ns/1ps
module lzinv_checker_test;
  localparam int SYM_W = 8, DICT_AW = 4, MAX_LEN = 7, IDX_W = 16, LEN_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic src_valid = 1'b0, cw_valid = 1'b0, err_clear = 1'b0;
  logic [SYM_W-1:0] src_sym = '0, cw_lit = '0;
  logic [DICT_AW-1:0] cw_dist = '0;
  logic [LEN_W-1:0] cw_len = '0;
  logic cw_ready, out_valid, err_pulse, err_sticky;
  logic [DICT_AW-1:0] out_dist;
  logic [LEN_W-1:0] out_len;
  logic [SYM_W-1:0] out_lit;
  logic [IDX_W-1:0] err_index;

  int errors = 0, checks = 0, nchk = 0;
  bit done = 1'b0;
  logic [SYM_W-1:0] hist [0:2047];

  always #2 clk = ~clk;

  lzinv_checker #(.SYM_W(SYM_W), .DICT_AW(DICT_AW), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_sym(src_sym),
    .cw_valid(cw_valid), .cw_dist(cw_dist), .cw_len(cw_len), .cw_lit(cw_lit),
    .cw_ready(cw_ready), .out_valid(out_valid), .out_dist(out_dist),
    .out_len(out_len), .out_lit(out_lit), .err_pulse(err_pulse),
    .err_index(err_index), .err_sticky(err_sticky), .err_clear(err_clear)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; src_valid = 1'b0; cw_valid = 1'b0; err_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; nchk = 0;
    @(negedge clk);
  endtask

  // late=1: codeword offered first, source symbols trickle in with gaps.
  task automatic send(input int k_src, input int k_cw, input int len,
                      input int lit_src, input int lit_cw, input bit late);
    logic [SYM_W-1:0] s [0:7];
    logic [SYM_W-1:0] r;
    int first = -1;
    int cyc = 0;
    bit early = 1'b0;
    for (int i = 0; i <= len; i++) begin
      r    = (i < len) ? hist[nchk + i - k_cw - 1] : SYM_W'(lit_cw);
      s[i] = (i < len) ? hist[nchk + i - k_src - 1] : SYM_W'(lit_src);
      hist[nchk + i] = r;
      if (first < 0 && r != s[i]) first = i;
    end
    if (!late) begin
      for (int i = 0; i <= len; i++) begin
        @(negedge clk); src_valid = 1'b1; src_sym = s[i];
      end
      @(negedge clk); src_valid = 1'b0;
    end
    chk(cw_ready == 1'b1, "R6", "cw_ready idle", cw_ready, 1);
    cw_valid = 1'b1; cw_dist = DICT_AW'(k_cw); cw_len = LEN_W'(len); cw_lit = SYM_W'(lit_cw);
    @(negedge clk); cw_valid = 1'b0;
    if (late) begin
      for (int i = 0; i <= len; i++) begin
        if (out_valid || err_pulse) early = 1'b1;
        @(negedge clk); src_valid = 1'b1; src_sym = s[i];
        @(negedge clk); src_valid = 1'b0;
        if (i < len && (out_valid || err_pulse)) early = 1'b1;
      end
      // R3: no result before the final source symbol
      chk(!early, "R3", "result before last source symbol", early, 0);
    end
    while (!(out_valid || err_pulse) && cyc < 40) begin
      @(negedge clk); cyc++;
    end
    if (!late) chk(cyc == len + 1, "R6", "latency", cyc, len + 1);
    if (first < 0) begin
      chk(out_valid && !err_pulse, "R4", "release", {out_valid, err_pulse}, 2);
      chk(out_dist == DICT_AW'(k_cw) && out_len == LEN_W'(len) && out_lit == SYM_W'(lit_cw),
          "R2", "released fields", {out_dist, out_len, out_lit}, {k_cw[3:0], len[2:0], lit_cw[7:0]});
    end else begin
      chk(err_pulse && !out_valid, "R5", "withheld with error", {out_valid, err_pulse}, 1);
      chk(int'(err_index) == nchk + first, "R5", "err_index", err_index, nchk + first);
    end
    nchk += len + 1;
    @(negedge clk);
    if (first < 0) chk(!out_valid, "R4", "one-cycle release", out_valid, 0);
    else chk(!err_pulse, "R5", "one-cycle pulse", err_pulse, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk(!out_valid && !err_pulse && !err_sticky && cw_ready, "R1", "reset state",
        {out_valid, err_pulse, err_sticky, cw_ready}, 1);
    for (int j = 0; j < 9; j++) send(0, 0, 0, j * 29 + 3, j * 29 + 3, 1'b0);
    // R2 sweep: every length against every distance 1..8, overlap included
    for (int len = 0; len <= MAX_LEN; len++)
      for (int k = 0; k < 8; k++)
        send(k, k, len, ((len * 8 + k) * 37 + 11) & 255, ((len * 8 + k) * 37 + 11) & 255, 1'b0);
    chk(!err_sticky, "R8", "sticky clear after clean run", err_sticky, 0);
    // R3 stall with late source symbols
    send(1, 1, 5, 77, 77, 1'b1);
    send(3, 3, 2, 91, 91, 1'b1);
    // R5 corrupted literal and wrong distance
    send(2, 2, 3, 200, 201, 1'b0);
    chk(err_sticky, "R8", "sticky set", err_sticky, 1);
    send(0, 3, 4, 55, 55, 1'b0);
    send(4, 1, 6, 66, 66, 1'b1);
    send(5, 5, 7, 12, 12, 1'b0);
    chk(err_sticky, "R8", "sticky held", err_sticky, 1);
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
    chk(!err_sticky, "R8", "sticky cleared", err_sticky, 0);
    // R7 overflow: nine pushes into eight entries
    do_reset();
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); src_valid = 1'b1; src_sym = SYM_W'(i);
      if (i > 0) chk(!err_pulse, "R7", "no early overflow", err_pulse, 0);
    end
    @(negedge clk); src_valid = 1'b0;
    chk(err_pulse, "R7", "overflow pulse", err_pulse, 1);
    chk(err_index == 16'd8, "R7", "dropped index", err_index, 8);
    @(negedge clk);
    chk(!err_pulse && err_sticky, "R8", "sticky after pulse", {err_pulse, err_sticky}, 1);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule